// File: doc/BRIEF.md
# Flash Controller Reset Sequencer

This block decides how an embedded flash controller reacts to three active-low reset inputs: power-on, master and system. Power-on reset acts asynchronously and clears everything. Master and system reset are sampled on the clock. The control register holds a reset-inhibit bit, and while that bit is set both of them are ignored. The control register also holds a high-voltage enable bit and a wait-state field. The block owns a small register file, and software reaches it through a request/done access port.

A master reset starts a fixed sequence. If high voltage is on, the block first asks the high-voltage circuitry to shut down and waits for its acknowledge. It then copies one shadow word per clock into the register file, which restores the defaults. It then holds the bus interface off until the reset input is released, and becomes ready on the next clock. A system reset only clears the high-voltage enable and holds the bus interface off while it is applied. Master reset wins when both are low. Any register access is refused while a reset that is not inhibited is in force. An access that a reset interrupts is dropped without effect.

The control register is register 0: bit 0 is the high-voltage enable, bit 1 is the reset inhibit, and bits 3:2 are the wait-state count W.

Top module: `frst_top`

## Requirements
- R1: A low por_n asynchronously clears every register, including the inhibit and high-voltage bits, and abandons any sequence or access in progress. After release the bus interface is ready and register 0 reads 0.
- R2: While master or system reset is low and the inhibit bit is 0, biu_ready is 0, acc_refused equals acc_req, and no access completes.
- R3: With the inhibit bit at 1, a low mrst_n starts no sequence and changes no register, and accesses still complete normally.
- R4: If the high-voltage bit is 1 when master reset is taken, hv_off_req rises on the next clock and the high-voltage bit clears one clock later. No shadow read happens until hv_off_ack has been seen.
- R5: The shadow copy asserts shd_rd on NREG consecutive clocks with shd_addr at 0,1,...,NREG-1 and loads register k with shadow word k. In register 0, bits 0 and 1 are forced to 0.
- R6: Once the copy has finished, biu_ready is 1 no more than 4 clocks after the first clock on which mrst_n is sampled high (this design takes 1).
- R7: When master and system reset go low together, master reset takes effect and runs the full sequence.
- R8: A system reset with the inhibit bit at 0 clears the high-voltage bit, leaves all other register bits unchanged, and holds biu_ready at 0 while it is low.
- R9: With the inhibit bit at 1, a system reset has no effect: the high-voltage bit stays set and biu_ready stays 1.
- R10: An accepted access asserts acc_done exactly 1+W clocks after the clock that accepted it, so an access lasts 2+W clocks. W is the value of register 0 bits 3:2 at acceptance.
- R11: A completed write stores acc_wdata in register acc_addr. A completed read returns that register on acc_rdata while acc_done is 1.
- R12: If a reset interrupts an access that is in progress, acc_done never rises for it and its write does not happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Master reset, active low |
| srst_n | input | 1 | System reset, active low |
| acc_req | input | 1 | Register access request, held until done |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Register index |
| acc_wdata | input | DW | Write data |
| acc_rdata | output | DW | Read data, valid with acc_done |
| acc_done | output | 1 | Access complete |
| acc_refused | output | 1 | Request refused because a reset is active |
| biu_ready | output | 1 | Bus interface ready for a new cycle |
| hv_en | output | 1 | High-voltage enable bit |
| rst_inhibit | output | 1 | Reset-inhibit bit |
| hv_off_req | output | 1 | High-voltage shutdown request |
| hv_off_ack | input | 1 | High-voltage shutdown acknowledge |
| shd_rd | output | 1 | Shadow word read strobe |
| shd_addr | output | AW | Shadow word index |
| shd_data | input | DW | Shadow word data |

## Verification
The bench aims at orderings where a wrong design shows itself. It takes a master reset with high voltage on and a slow acknowledge: a design that copied first would read the shadow while the enable was still high. It applies master and system reset together: a design with the priority inverted would clear only the high-voltage bit and skip the reload. It applies an inhibited master reset and an inhibited system reset: a design that ignored the inhibit bit would drop ready or clear the bit. It interrupts a slow write with a system reset and pulls power-on reset partway through a sequence: an incomplete abort would leave a stray done pulse, a committed write, or a stuck shutdown request.

// File: rtl/frst_pkg.sv
package frst_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_HVOFF = 2'd1,
      SQ_COPY  = 2'd2,
      SQ_HOLD  = 2'd3
   } seq_st_t;

   localparam int CTL_HV  = 0;
   localparam int CTL_INH = 1;
   localparam int CTL_WT  = 2;
endpackage

// File: rtl/frst_seq.sv
module frst_seq
   import frst_pkg::*;
#(
   parameter int NREG = 4,
   parameter int AW   = 2
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          mrst_n,
   input  logic          inhibit,
   input  logic          hv_on,
   input  logic          hv_off_ack,
   output seq_st_t       state,
   output logic          hv_off_req,
   output logic          shd_rd,
   output logic [AW-1:0] shd_addr
);
   localparam logic [AW-1:0] LAST = AW'(NREG - 1);

   seq_st_t       st_q;
   logic [AW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: begin
               cnt_q <= '0;
               if (!mrst_n && !inhibit) st_q <= hv_on ? SQ_HVOFF : SQ_COPY;
            end
            SQ_HVOFF: if (hv_off_ack) st_q <= SQ_COPY;
            SQ_COPY: begin
               if (cnt_q == LAST) st_q <= SQ_HOLD;
               else               cnt_q <= cnt_q + 1'b1;
            end
            SQ_HOLD:  if (mrst_n) st_q <= SQ_IDLE;
            default:  st_q <= SQ_IDLE;
         endcase
      end
   end

   assign state      = st_q;
   assign hv_off_req = (st_q == SQ_HVOFF);
   assign shd_rd     = (st_q == SQ_COPY);
   assign shd_addr   = cnt_q;

   assert_copy_order_R5: assert property (@(posedge clk) disable iff (!por_n)
      (shd_rd && $past(shd_rd)) |-> (shd_addr == AW'($past(shd_addr) + 1'b1)));

   assert_inhibit_holds_R3: assert property (@(posedge clk) disable iff (!por_n)
      (state == SQ_IDLE && inhibit) |=> (state == SQ_IDLE));

   assert_ack_before_copy_R4: assert property (@(posedge clk) disable iff (!por_n)
      ($past(state) == SQ_HVOFF && state == SQ_COPY) |-> $past(hv_off_ack));
endmodule

// File: rtl/frst_regs.sv
module frst_regs
   import frst_pkg::*;
#(
   parameter int NREG = 4,
   parameter int DW   = 8,
   parameter int AW   = 2
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          copy_we,
   input  logic [AW-1:0] copy_idx,
   input  logic [DW-1:0] copy_data,
   input  logic          sw_we,
   input  logic [AW-1:0] sw_idx,
   input  logic [DW-1:0] sw_data,
   input  logic          hv_clr,
   input  logic [AW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] ctrl
);
   logic [DW-1:0] q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [DW-1:0] LMASK = (i == 0) ?
         ~((DW'(1) << CTL_HV) | (DW'(1) << CTL_INH)) : {DW{1'b1}};
      logic [DW-1:0] d;

      always_comb begin
         d = q[i];
         if (copy_we && copy_idx == AW'(i))   d = copy_data & LMASK;
         else if (sw_we && sw_idx == AW'(i))  d = sw_data;
         if (i == 0 && hv_clr)                d[CTL_HV] = 1'b0;
      end

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) q[i] <= '0;
         else        q[i] <= d;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NREG; k++)
         if (rd_idx == AW'(k)) rd_data = q[k];
   end

   assign ctrl = q[0];

   assert_hv_cleared_R8: assert property (@(posedge clk) disable iff (!por_n)
      hv_clr |=> !ctrl[CTL_HV]);
endmodule

// File: rtl/frst_acc.sv
module frst_acc #(
   parameter int AW     = 2,
   parameter int DW     = 8,
   parameter int WAIT_W = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              req,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   input  logic [WAIT_W-1:0] wait_cfg,
   input  logic              block,
   output logic              busy,
   output logic              done,
   output logic              wr_en,
   output logic [AW-1:0]     cur_idx,
   output logic [DW-1:0]     wr_data
);
   logic [WAIT_W-1:0] wc_q;
   logic              we_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy    <= 1'b0;
         wc_q    <= '0;
         we_q    <= 1'b0;
         cur_idx <= '0;
         wr_data <= '0;
      end else if (block) begin
         busy <= 1'b0;
      end else if (busy) begin
         if (wc_q == '0) busy <= 1'b0;
         else            wc_q <= wc_q - 1'b1;
      end else if (req) begin
         busy    <= 1'b1;
         wc_q    <= wait_cfg;
         we_q    <= we;
         cur_idx <= addr;
         wr_data <= wdata;
      end
   end

   assign done  = busy && (wc_q == '0) && !block;
   assign wr_en = done && we_q;

   assert_abort_drops_R12: assert property (@(posedge clk) disable iff (!por_n)
      block |=> !busy);
endmodule

// File: rtl/frst_top.sv
module frst_top
   import frst_pkg::*;
#(
   parameter int NREG     = 4,
   parameter int DW       = 8,
   parameter int WAIT_W   = 2,
   parameter int MRST_MIN = 512,
   localparam int AW      = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          mrst_n,
   input  logic          srst_n,
   input  logic          acc_req,
   input  logic          acc_we,
   input  logic [AW-1:0] acc_addr,
   input  logic [DW-1:0] acc_wdata,
   output logic [DW-1:0] acc_rdata,
   output logic          acc_done,
   output logic          acc_refused,
   output logic          biu_ready,
   output logic          hv_en,
   output logic          rst_inhibit,
   output logic          hv_off_req,
   input  logic          hv_off_ack,
   output logic          shd_rd,
   output logic [AW-1:0] shd_addr,
   input  logic [DW-1:0] shd_data
);
   localparam int SEQ_CYC = NREG + 2;

   if (DW < CTL_WT + WAIT_W) begin : g_bad_width
      $error("frst_top: DW too small for control fields");
   end
   if (NREG < 1) begin : g_bad_depth
      $error("frst_top: NREG must be at least 1");
   end
   if (SEQ_CYC >= MRST_MIN) begin : g_bad_window
      $error("frst_top: shadow copy does not fit the master reset window");
   end

   seq_st_t       st;
   logic [DW-1:0] ctrl;
   logic          rst_active, sys_act, busy, wr_en;
   logic [AW-1:0] cur_idx;
   logic [DW-1:0] wr_data;

   assign rst_inhibit = ctrl[CTL_INH];
   assign hv_en       = ctrl[CTL_HV];
   assign rst_active  = (st != SQ_IDLE) || (!rst_inhibit && (!mrst_n || !srst_n));
   assign sys_act     = (st == SQ_IDLE) && !rst_inhibit && !srst_n && mrst_n;
   assign biu_ready   = !rst_active && !busy;
   assign acc_refused = acc_req && rst_active;

   frst_seq #(.NREG(NREG), .AW(AW)) u_seq (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .inhibit(rst_inhibit),
      .hv_on(hv_en), .hv_off_ack(hv_off_ack), .state(st),
      .hv_off_req(hv_off_req), .shd_rd(shd_rd), .shd_addr(shd_addr)
   );

   frst_regs #(.NREG(NREG), .DW(DW), .AW(AW)) u_regs (
      .clk(clk), .por_n(por_n), .copy_we(shd_rd), .copy_idx(shd_addr),
      .copy_data(shd_data), .sw_we(wr_en), .sw_idx(cur_idx), .sw_data(wr_data),
      .hv_clr(sys_act || hv_off_req), .rd_idx(cur_idx), .rd_data(acc_rdata),
      .ctrl(ctrl)
   );

   frst_acc #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W)) u_acc (
      .clk(clk), .por_n(por_n), .req(acc_req), .we(acc_we), .addr(acc_addr),
      .wdata(acc_wdata), .wait_cfg(ctrl[CTL_WT +: WAIT_W]), .block(rst_active),
      .busy(busy), .done(acc_done), .wr_en(wr_en), .cur_idx(cur_idx),
      .wr_data(wr_data)
   );

   assert_refuse_in_reset_R2: assert property (@(posedge clk) disable iff (!por_n)
      (!mrst_n && !rst_inhibit) |-> (!biu_ready && !acc_done));

   assert_ready_after_release_R6: assert property (@(posedge clk) disable iff (!por_n)
      (st == SQ_HOLD && mrst_n && srst_n) |=> biu_ready);
endmodule

// File: tb/frst_top_test.sv
module frst_top_test;
   localparam int PER  = 10;
   localparam int NREG = 4;
   localparam int DW   = 8;
   localparam int AW   = 2;

   logic clk = 1'b0;
   logic por_n = 1'b0, mrst_n = 1'b1, srst_n = 1'b1;
   logic acc_req = 1'b0, acc_we = 1'b0, hv_off_ack = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [DW-1:0] acc_wdata = '0;
   logic [DW-1:0] acc_rdata, shd_data;
   logic [AW-1:0] shd_addr;
   logic acc_done, acc_refused, biu_ready, hv_en, rst_inhibit, hv_off_req, shd_rd;

   int nchk = 0, nfail = 0, cyc = 0, ackcnt = 0;
   bit started = 1'b0;

   always #(PER/2) clk = ~clk;

   function automatic logic [DW-1:0] shw(int i);
      return DW'(8'hA5 + i * 8'h1D);
   endfunction

   assign shd_data = shw(int'(shd_addr));

   frst_top uut (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .srst_n(srst_n),
      .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_done(acc_done),
      .acc_refused(acc_refused), .biu_ready(biu_ready), .hv_en(hv_en),
      .rst_inhibit(rst_inhibit), .hv_off_req(hv_off_req),
      .hv_off_ack(hv_off_ack), .shd_rd(shd_rd), .shd_addr(shd_addr),
      .shd_data(shd_data)
   );

   task automatic chk(bit ok, string req, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // behavioural reference: states 0 idle, 1 shutdown wait, 2 copy, 3 hold
   int m_st = 0, m_cnt = 0, m_wc = 0, m_addr = 0;
   bit m_busy = 0, m_we = 0;
   logic [DW-1:0] m_wd = '0;
   logic [DW-1:0] m_reg [NREG] = '{default: '0};

   function automatic bit m_active();
      return (m_st != 0) || (!m_reg[0][1] && (!mrst_n || !srst_n));
   endfunction

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_st = 0; m_cnt = 0; m_busy = 0; m_wc = 0; m_we = 0; m_addr = 0; m_wd = '0;
         for (int k = 0; k < NREG; k++) m_reg[k] = '0;
      end else begin
         bit act, sys, dn, inh, hv;
         int wt;
         cyc++;
         inh = m_reg[0][1];
         hv  = m_reg[0][0];
         act = m_active();
         sys = (m_st == 0) && !inh && !srst_n && mrst_n;
         dn  = m_busy && m_wc == 0 && !act;
         wt  = int'(m_reg[0][3:2]);
         if (m_st == 2) begin
            m_reg[m_cnt] = shw(m_cnt);
            if (m_cnt == 0) m_reg[0][1:0] = 2'b00;
         end else if (dn && m_we && m_addr < NREG) begin
            m_reg[m_addr] = m_wd;
         end
         if (sys || m_st == 1) m_reg[0][0] = 1'b0;
         if (act) m_busy = 0;
         else if (m_busy) begin
            if (m_wc == 0) m_busy = 0; else m_wc--;
         end else if (acc_req) begin
            m_busy = 1; m_wc = wt; m_we = acc_we; m_addr = int'(acc_addr); m_wd = acc_wdata;
         end
         case (m_st)
            0: begin m_cnt = 0; if (!mrst_n && !inh) m_st = hv ? 1 : 2; end
            1: if (hv_off_ack) m_st = 2;
            2: if (m_cnt == NREG - 1) m_st = 3; else m_cnt++;
            default: if (mrst_n) m_st = 0;
         endcase
      end
   end

   // per-cycle comparison, a quarter period after the falling edge
   always begin
      @(negedge clk);
      #(PER/4);
      if (started) begin
         bit act, dn;
         act = m_active();
         dn  = m_busy && m_wc == 0 && !act;
         chk(biu_ready == (!act && !m_busy), "R6 biu_ready", biu_ready, !act && !m_busy);
         chk(acc_refused == (acc_req && act), "R2 acc_refused", acc_refused, acc_req && act);
         chk(hv_en == m_reg[0][0], "R4 hv_en", hv_en, m_reg[0][0]);
         chk(rst_inhibit == m_reg[0][1], "R3 rst_inhibit", rst_inhibit, m_reg[0][1]);
         chk(hv_off_req == (m_st == 1), "R4 hv_off_req", hv_off_req, m_st == 1);
         chk(shd_rd == (m_st == 2), "R5 shd_rd", shd_rd, m_st == 2);
         if (m_st == 2) chk(int'(shd_addr) == m_cnt, "R5 shd_addr", shd_addr, m_cnt);
         chk(acc_done == dn, "R10 acc_done", acc_done, dn);
         if (dn && !m_we)
            chk(acc_rdata == (m_addr < NREG ? m_reg[m_addr] : '0), "R11 acc_rdata",
                acc_rdata, m_reg[m_addr]);
      end
   end

   // shutdown acknowledge arrives four cycles after the request
   always @(negedge clk) begin
      if (!hv_off_req) begin ackcnt = 0; hv_off_ack = 1'b0; end
      else begin ackcnt++; if (ackcnt >= 4) hv_off_ack = 1'b1; end
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_acc(bit we, int addr, logic [DW-1:0] wd,
                         output logic [DW-1:0] rd, output int lat);
      @(negedge clk);
      acc_req = 1'b1; acc_we = we; acc_addr = AW'(addr); acc_wdata = wd;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!acc_done && lat < 20);
      rd = acc_rdata;
      acc_req = 1'b0; acc_we = 1'b0;
   endtask

   task automatic wait_ready(string req);
      int w = 0;
      while (!biu_ready && w < 10) begin wait_cyc(1); w++; end
      chk(w >= 1 && w <= 4, req, w, 1);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [DW-1:0] rd;
      int lat;
      // R1: power-on state
      wait_cyc(4);
      por_n = 1'b1;
      started = 1'b1;
      wait_cyc(1);
      chk(biu_ready == 1'b1, "R1 ready after power-on", biu_ready, 1);
      chk(hv_en == 1'b0 && rst_inhibit == 1'b0, "R1 control bits", {hv_en, rst_inhibit}, 0);
      do_acc(0, 0, '0, rd, lat);
      chk(rd == 8'h00, "R1 reg0 after power-on", rd, 0);
      chk(lat == 1, "R10 latency W=0", lat, 1);

      // R10 / R11: wait states and data
      do_acc(1, 0, 8'h08, rd, lat);
      do_acc(0, 0, '0, rd, lat);
      chk(lat == 3, "R10 latency W=2", lat, 3);
      chk(rd == 8'h08, "R11 reg0 readback", rd, 8'h08);
      do_acc(1, 2, 8'h5A, rd, lat);
      do_acc(0, 2, '0, rd, lat);
      chk(rd == 8'h5A, "R11 reg2 readback", rd, 8'h5A);
      do_acc(1, 0, 8'h0C, rd, lat);
      do_acc(0, 0, '0, rd, lat);
      chk(lat == 4, "R10 latency W=3", lat, 4);
      do_acc(1, 0, 8'h01, rd, lat);

      // R4 / R5 / R6 / R2: master reset with high voltage on
      wait_cyc(1);
      mrst_n = 1'b0;
      wait_cyc(1);
      chk(hv_off_req == 1'b1, "R4 shutdown request", hv_off_req, 1);
      chk(shd_rd == 1'b0, "R4 no shadow read before ack", shd_rd, 0);
      wait_cyc(1);
      chk(hv_en == 1'b0, "R4 hv bit dropped", hv_en, 0);
      chk(shd_rd == 1'b0, "R4 still waiting for ack", shd_rd, 0);
      acc_req = 1'b1;
      wait_cyc(1);
      chk(acc_refused == 1'b1, "R2 access refused", acc_refused, 1);
      acc_req = 1'b0;
      wait_cyc(520);
      mrst_n = 1'b1;
      wait_ready("R6 ready after master release");
      for (int k = 0; k < NREG; k++) begin
         logic [DW-1:0] e;
         e = shw(k);
         if (k == 0) e[1:0] = 2'b00;
         do_acc(0, k, '0, rd, lat);
         chk(rd == e, "R5 shadow default", rd, e);
      end

      // R1: power-on reset in the middle of a sequence
      do_acc(1, 0, 8'h01, rd, lat);
      wait_cyc(1);
      mrst_n = 1'b0;
      wait_cyc(3);
      por_n = 1'b0;
      wait_cyc(2);
      por_n = 1'b1; mrst_n = 1'b1;
      wait_cyc(1);
      chk(hv_off_req == 1'b0, "R1 sequence abandoned", hv_off_req, 0);
      do_acc(0, 0, '0, rd, lat);
      chk(rd == 8'h00, "R1 reg0 cleared", rd, 0);

      // R3 / R9: inhibit bit set
      do_acc(1, 0, 8'h03, rd, lat);
      do_acc(1, 1, 8'h44, rd, lat);
      wait_cyc(1);
      mrst_n = 1'b0;
      wait_cyc(10);
      chk(biu_ready == 1'b1, "R3 ready under inhibited master", biu_ready, 1);
      do_acc(0, 1, '0, rd, lat);
      chk(rd == 8'h44 && lat == 1, "R3 access during inhibited master", rd, 8'h44);
      mrst_n = 1'b1;
      wait_cyc(1);
      srst_n = 1'b0;
      wait_cyc(10);
      chk(biu_ready == 1'b1, "R9 ready under inhibited system", biu_ready, 1);
      chk(hv_en == 1'b1, "R9 hv kept", hv_en, 1);
      srst_n = 1'b1;

      // R8: system reset
      do_acc(1, 0, 8'h01, rd, lat);
      wait_cyc(1);
      srst_n = 1'b0;
      wait_cyc(1);
      chk(biu_ready == 1'b0, "R8 not ready in system reset", biu_ready, 0);
      chk(hv_en == 1'b0, "R8 hv cleared", hv_en, 0);
      wait_cyc(3);
      srst_n = 1'b1;
      wait_ready("R8 ready after system release");
      do_acc(0, 0, '0, rd, lat);
      chk(rd == 8'h00, "R8 reg0 after system reset", rd, 0);
      do_acc(0, 1, '0, rd, lat);
      chk(rd == 8'h44, "R8 reg1 unchanged", rd, 8'h44);

      // R7: master and system together
      do_acc(1, 0, 8'h01, rd, lat);
      do_acc(1, 1, 8'h77, rd, lat);
      wait_cyc(1);
      mrst_n = 1'b0; srst_n = 1'b0;
      wait_cyc(1);
      chk(hv_off_req == 1'b1, "R7 master sequence taken", hv_off_req, 1);
      wait_cyc(520);
      mrst_n = 1'b1; srst_n = 1'b1;
      wait_ready("R7 ready after joint release");
      do_acc(0, 1, '0, rd, lat);
      chk(rd == shw(1), "R7 reg1 reloaded", rd, shw(1));

      // R12: reset interrupts a slow write
      do_acc(1, 0, 8'h0C, rd, lat);
      @(negedge clk);
      acc_req = 1'b1; acc_we = 1'b1; acc_addr = 2'd1; acc_wdata = 8'h33;
      wait_cyc(2);
      srst_n = 1'b0;
      for (int k = 0; k < 4; k++) begin
         wait_cyc(1);
         chk(acc_done == 1'b0, "R12 no done after abort", acc_done, 0);
      end
      acc_req = 1'b0; acc_we = 1'b0;
      srst_n = 1'b1;
      wait_ready("R12 ready after abort");
      do_acc(0, 1, '0, rd, lat);
      chk(rd == shw(1), "R12 aborted write not stored", rd, shw(1));
      chk(lat == 4, "R10 latency W=3 after abort", lat, 4);

      wait_cyc(3);
      summary();
   end
endmodule